// File: doc/BRIEF.md
# Colored Store Buffer with Load Forwarding

This block holds stores between allocation and their write to memory. Each store receives a ring identifier when it is allocated, in program order. Its address half and its data half then arrive independently, in either order, and are written into the entry that identifier names. Every load carries a color: the identifier of the youngest store allocated ahead of it. When the load issues, the buffer looks only at stores of that color or older. If one of them writes the same starting address, the buffer either forwards that store's data to the load or tells the load to wait.

The retire input promotes the oldest non-senior store to senior. Senior stores leave for memory strictly oldest first, over a valid/ready write port. The block starts a write only while the bus reports idle or while the buffer is full, and it holds an offered write steady until the write is accepted. A flush throws away all stores that are not yet senior and keeps the senior ones until they drain.

Top module: `colored_sb`

## Requirements
- R1: Identifiers are `{wrap, index}` with index counting 0 to DEPTH-1. Identifiers are handed out in order from 0 after reset, and the wrap bit toggles each time the index rolls over. `alloc_ready` is low while DEPTH stores are live.
- R2: `last_id` shows the identifier of the most recently allocated live store.
- R3: The address micro-op and the data micro-op of a store fill its entry in either order. Forwarding works once both halves are present.
- R4: A load compares only against live stores whose identifier is at or before its tag in program order. Younger stores are ignored.
- R5: When several eligible stores share the load's starting address, the youngest of them decides the response.
- R6: A load forwards (`ld_fwd`=1, `ld_data`=the store's data) only if the deciding store has its data and the load size code is no larger than the store size code. Size codes are log2 of the byte count. Otherwise the load gets `ld_block`=1. The two outputs are never high together.
- R7: A load with no address match among eligible stores gets neither `ld_fwd` nor `ld_block`.
- R8: Each `retire_valid` makes the oldest non-senior store senior. Only senior stores are written to memory, and they are written in program order.
- R9: A write is first offered only while `bus_idle` is high or the buffer is full. Once offered, `mem_valid` and its address stay until `mem_ready`.
- R10: `flush` frees every non-senior store, so the next allocation reuses the first freed identifier and the freed entries no longer forward. Senior stores stay and still drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate one store this cycle |
| alloc_ready | output | 1 | A free entry exists |
| alloc_id | output | IDW | Identifier the next allocation receives |
| last_id | output | IDW | Identifier of the youngest allocated store |
| sta_valid | input | 1 | Store-address micro-op completes |
| sta_id | input | IDW | Store it belongs to |
| sta_addr | input | AW | Starting address |
| sta_size | input | SW | Size code (log2 bytes) |
| std_valid | input | 1 | Store-data micro-op completes |
| std_id | input | IDW | Store it belongs to |
| std_data | input | DW | Store data |
| retire_valid | input | 1 | Promote the oldest non-senior store |
| flush | input | 1 | Discard all non-senior stores |
| ld_valid | input | 1 | Load issues this cycle |
| ld_tag | input | IDW | Load color |
| ld_addr | input | AW | Load starting address |
| ld_size | input | SW | Load size code |
| ld_fwd | output | 1 | Data forwarded |
| ld_block | output | 1 | Load must wait |
| ld_data | output | DW | Forwarded data |
| bus_idle | input | 1 | Memory bus is idle |
| mem_valid | output | 1 | Write offered |
| mem_ready | input | 1 | Write accepted |
| mem_addr | output | AW | Write address |
| mem_data | output | DW | Write data |
| mem_size | output | SW | Write size code |

## Verification
The bench builds the block with DEPTH=4, AW=16 and DW=32, so identifiers are three bits wide. With this depth a few allocations fill the buffer, which exercises the full-triggered drain and the `alloc_ready` cut-off. A short run also carries the ring past its wrap point, so the color comparison is checked across a toggled wrap bit. The flush case reuses a discarded identifier whose entry still holds an old address, which shows that stale entries cannot forward.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Distance from the ring head to pointer p, modulo 2*depth.
  // Values below depth lie inside or ahead of the window; the upper half is behind the head.
  function automatic int ring_off(int p_idx, bit p_wrap, int h_idx, bit h_wrap, int depth);
    int d;
    if (p_wrap == h_wrap) d = (p_idx >= h_idx) ? p_idx - h_idx : p_idx - h_idx + 2*depth;
    else                  d = p_idx + depth - h_idx;
    return d;
  endfunction
endpackage

// File: rtl/sb_fwd_match.sv
module sb_fwd_match import sb_pkg::*; #(
  parameter int DEPTH = 12,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SW    = 2,
  localparam int IXW  = $clog2(DEPTH),
  localparam int IDW  = IXW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDW-1:0]      head,
  input  logic [IDW:0]        live_cnt,
  input  logic                ld_valid,
  input  logic [IDW-1:0]      ld_tag,
  input  logic [AW-1:0]       ld_addr,
  input  logic [SW-1:0]       ld_size,
  input  logic [AW-1:0]       e_addr [DEPTH],
  input  logic [DW-1:0]       e_data [DEPTH],
  input  logic [SW-1:0]       e_size [DEPTH],
  input  logic [DEPTH-1:0]    e_aok,
  input  logic [DEPTH-1:0]    e_dok,
  output logic                ld_fwd,
  output logic                ld_block,
  output logic [DW-1:0]       ld_data
);
  logic           found;
  logic [IXW-1:0] best_ix;

  always_comb begin
    int t_off, best_off, h_ix, e_off;
    h_ix     = int'(head[IXW-1:0]);
    t_off    = ring_off(int'(ld_tag[IXW-1:0]), ld_tag[IXW], h_ix, head[IXW], DEPTH);
    found    = 1'b0;
    best_off = 0;
    best_ix  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      e_off = (i >= h_ix) ? i - h_ix : i + DEPTH - h_ix;
      if (e_off < int'(live_cnt) && t_off < DEPTH && e_off <= t_off &&
          e_aok[i] && e_addr[i] == ld_addr && (!found || e_off > best_off)) begin
        found    = 1'b1;
        best_off = e_off;
        best_ix  = IXW'(i);
      end
    end
  end

  wire can_fwd = e_dok[best_ix] && (ld_size <= e_size[best_ix]);
  assign ld_fwd   = ld_valid && found && can_fwd;
  assign ld_block = ld_valid && found && !can_fwd;
  assign ld_data  = e_data[best_ix];

  // R6
  fwd_block_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_fwd && ld_block));
endmodule

// File: rtl/sb_drain_ctl.sv
module sb_drain_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic senior_avail,
  input  logic bus_idle,
  input  logic full,
  input  logic mem_ready,
  output logic mem_valid,
  output logic drain_fire
);
  logic hold;

  assign mem_valid  = senior_avail && (bus_idle || full || hold);
  assign drain_fire = mem_valid && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) hold <= 1'b0;
    else        hold <= mem_valid && !mem_ready;
  end

  // R9
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid);
  // R9
  drain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |=> !mem_valid || bus_idle || full);
endmodule

// File: rtl/colored_sb.sv
module colored_sb import sb_pkg::*; #(
  parameter int DEPTH = 12,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SW    = 2,
  localparam int IXW  = $clog2(DEPTH),
  localparam int IDW  = IXW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_valid,
  output logic           alloc_ready,
  output logic [IDW-1:0] alloc_id,
  output logic [IDW-1:0] last_id,
  input  logic           sta_valid,
  input  logic [IDW-1:0] sta_id,
  input  logic [AW-1:0]  sta_addr,
  input  logic [SW-1:0]  sta_size,
  input  logic           std_valid,
  input  logic [IDW-1:0] std_id,
  input  logic [DW-1:0]  std_data,
  input  logic           retire_valid,
  input  logic           flush,
  input  logic           ld_valid,
  input  logic [IDW-1:0] ld_tag,
  input  logic [AW-1:0]  ld_addr,
  input  logic [SW-1:0]  ld_size,
  output logic           ld_fwd,
  output logic           ld_block,
  output logic [DW-1:0]  ld_data,
  input  logic           bus_idle,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_data,
  output logic [SW-1:0]  mem_size
);
  function automatic logic [IDW-1:0] p_inc(logic [IDW-1:0] p);
    return (int'(p[IXW-1:0]) == DEPTH-1) ? {~p[IXW], {IXW{1'b0}}} : p + 1'b1;
  endfunction
  function automatic logic [IDW-1:0] p_dec(logic [IDW-1:0] p);
    return (p[IXW-1:0] == '0) ? {~p[IXW], IXW'(DEPTH-1)} : p - 1'b1;
  endfunction

  logic [IDW-1:0]   head, sen, tail;
  logic [AW-1:0]    e_addr [DEPTH];
  logic [DW-1:0]    e_data [DEPTH];
  logic [SW-1:0]    e_size [DEPTH];
  logic [DEPTH-1:0] e_aok, e_dok;
  logic [IDW:0]     live_cnt;
  logic             full, drain_fire, alloc_fire, retire_fire;

  assign live_cnt    = (IDW+1)'(ring_off(int'(tail[IXW-1:0]), tail[IXW],
                                         int'(head[IXW-1:0]), head[IXW], DEPTH));
  assign full        = (int'(live_cnt) == DEPTH);
  assign alloc_ready = !full;
  assign alloc_fire  = alloc_valid && !full && !flush;
  assign retire_fire = retire_valid && (sen != tail);
  assign alloc_id    = tail;
  assign last_id     = p_dec(tail);

  wire [IDW-1:0] sen_nxt = retire_fire ? p_inc(sen) : sen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0; sen <= '0; tail <= '0;
    end else begin
      if (drain_fire) head <= p_inc(head);
      sen <= sen_nxt;
      if (flush)           tail <= sen_nxt;
      else if (alloc_fire) tail <= p_inc(tail);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_aok <= '0;
      e_dok <= '0;
    end else begin
      if (alloc_fire) begin
        e_aok[tail[IXW-1:0]] <= 1'b0;
        e_dok[tail[IXW-1:0]] <= 1'b0;
      end
      if (sta_valid) e_aok[sta_id[IXW-1:0]] <= 1'b1;
      if (std_valid) e_dok[std_id[IXW-1:0]] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (sta_valid) begin
      e_addr[sta_id[IXW-1:0]] <= sta_addr;
      e_size[sta_id[IXW-1:0]] <= sta_size;
    end
    if (std_valid) e_data[std_id[IXW-1:0]] <= std_data;
  end

  sb_fwd_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .SW(SW)) u_match (
    .clk(clk), .rst_n(rst_n), .head(head), .live_cnt(live_cnt),
    .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr), .ld_size(ld_size),
    .e_addr(e_addr), .e_data(e_data), .e_size(e_size), .e_aok(e_aok), .e_dok(e_dok),
    .ld_fwd(ld_fwd), .ld_block(ld_block), .ld_data(ld_data));

  sb_drain_ctl u_drain (
    .clk(clk), .rst_n(rst_n), .senior_avail(head != sen), .bus_idle(bus_idle),
    .full(full), .mem_ready(mem_ready), .mem_valid(mem_valid), .drain_fire(drain_fire));

  assign mem_addr = e_addr[head[IXW-1:0]];
  assign mem_data = e_data[head[IXW-1:0]];
  assign mem_size = e_size[head[IXW-1:0]];

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && !flush && !alloc_ready |=> $stable(tail));
  // R8
  senior_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> head != sen);
  // R9
  drain_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> $stable(mem_addr));
  // R10
  flush_keep_senior_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !retire_valid |=> tail == $past(sen));
endmodule

// File: tb/colored_sb_tb.sv
module colored_sb_tb;
  localparam int DEPTH = 4, AW = 16, DW = 32, SW = 2, IDW = 3;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, sta_valid = 0, std_valid = 0, retire_valid = 0, flush = 0;
  logic ld_valid = 0, bus_idle = 0, mem_ready = 0;
  logic [IDW-1:0] sta_id = 0, std_id = 0, ld_tag = 0;
  logic [AW-1:0] sta_addr = 0, ld_addr = 0;
  logic [SW-1:0] sta_size = 0, ld_size = 0;
  logic [DW-1:0] std_data = 0;
  logic alloc_ready, ld_fwd, ld_block, mem_valid;
  logic [IDW-1:0] alloc_id, last_id;
  logic [DW-1:0] ld_data, mem_data;
  logic [AW-1:0] mem_addr;
  logic [SW-1:0] mem_size;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  colored_sb #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .SW(SW)) u_dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic alloc(input logic [IDW-1:0] exp, input string req);
    alloc_valid = 1; #1 chk(req, alloc_id, exp);
    step(); alloc_valid = 0;
  endtask

  task automatic sta(input logic [IDW-1:0] id, input logic [AW-1:0] a, input logic [SW-1:0] s);
    sta_valid = 1; sta_id = id; sta_addr = a; sta_size = s; step(); sta_valid = 0;
  endtask

  task automatic stdata(input logic [IDW-1:0] id, input logic [DW-1:0] d);
    std_valid = 1; std_id = id; std_data = d; step(); std_valid = 0;
  endtask

  // expected response: 0 none, 1 forward, 2 block
  task automatic load(input logic [IDW-1:0] tag, input logic [AW-1:0] a, input logic [SW-1:0] s,
                      input int resp, input logic [DW-1:0] d, input string req);
    ld_valid = 1; ld_tag = tag; ld_addr = a; ld_size = s; #1;
    chk(req, {ld_fwd, ld_block}, (resp == 1) ? 2'b10 : (resp == 2) ? 2'b01 : 2'b00);
    if (resp == 1) chk(req, ld_data, d);
    ld_valid = 0;
  endtask

  task automatic t_reset();
    #1 chk("R1 reset ready", alloc_ready, 1);
    chk("R1 reset id", alloc_id, 0);
    chk("R8 reset idle", mem_valid, 0);
    load(0, 16'h100, 2, 0, 0, "R7 empty");
  endtask

  task automatic t_forward();
    alloc(0, "R1 id0"); alloc(1, "R1 id1"); alloc(2, "R1 id2");
    #1 chk("R2 last", last_id, 2);
    stdata(0, 32'hAAAA0000); sta(0, 16'h100, 2);     // data before address
    sta(1, 16'h100, 2);
    sta(2, 16'h200, 1); stdata(2, 32'h1234);
    load(0, 16'h100, 2, 1, 32'hAAAA0000, "R3 R4 older only");
    load(1, 16'h100, 2, 2, 0, "R5 youngest no data");
    stdata(1, 32'hBBBB);
    load(1, 16'h100, 2, 1, 32'hBBBB, "R5 youngest fwd");
    load(2, 16'h200, 2, 2, 0, "R6 size too big");
    load(2, 16'h200, 0, 1, 32'h1234, "R6 smaller size");
    load(2, 16'h300, 2, 0, 0, "R7 no match");
  endtask

  task automatic t_full();
    alloc(3, "R1 id3");
    #1 chk("R1 full", alloc_ready, 0);
    sta(3, 16'h300, 2); stdata(3, 32'h3333);
    load(3, 16'h300, 2, 1, 32'h3333, "R4 own tag");
    #1 chk("R8 no senior no drain", mem_valid, 0);
  endtask

  task automatic t_drain();
    retire_valid = 1; step(); step(); retire_valid = 0;
    #1 chk("R9 full drains", mem_valid, 1);
    chk("R8 oldest first", mem_addr, 16'h100);
    chk("R8 oldest data", mem_data, 32'hAAAA0000);
    step();
    #1 chk("R9 hold", mem_valid, 1);
    mem_ready = 1; step(); mem_ready = 0;
    #1 chk("R9 not idle not full", mem_valid, 0);
    bus_idle = 1;
    #1 chk("R9 idle drains", mem_valid, 1);
    chk("R8 second data", mem_data, 32'hBBBB);
    mem_ready = 1; step(); mem_ready = 0;
    #1 chk("R8 unretired stays", mem_valid, 0);
    bus_idle = 0;
  endtask

  task automatic t_flush();
    retire_valid = 1; step(); retire_valid = 0;
    flush = 1; step(); flush = 0;
    alloc(3, "R10 reuse id");
    load(3, 16'h300, 2, 0, 0, "R10 freed no fwd");
    bus_idle = 1;
    #1 chk("R10 senior kept", mem_valid, 1);
    chk("R10 senior addr", mem_addr, 16'h200);
    mem_ready = 1; step(); mem_ready = 0; bus_idle = 0;
  endtask

  task automatic t_wrap();
    alloc(3'b100, "R1 wrap id");
    #1 chk("R2 last wrap", last_id, 3'b100);
    sta(3'b100, 16'h400, 2); stdata(3'b100, 32'h44);
    load(3'b100, 16'h400, 2, 1, 32'h44, "R4 wrap tag");
    load(3, 16'h400, 2, 0, 0, "R4 younger ignored");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1; @(negedge clk);
        t_reset(); t_forward(); t_full(); t_drain(); t_flush(); t_wrap();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule